// File: doc/BRIEF.md
# Shared-Adder Four-Function ALU

A combinational arithmetic logic unit that takes two operands of equal width and a 2-bit function code. It returns one of four results: bitwise AND, bitwise OR, the sum, or the difference. The default operand width is 8 bits. Addition and subtraction share a single ripple-carry adder. The low function bit does two jobs: it swaps the adder's second operand for its bitwise complement, and it supplies the adder's carry-in, which adds the +1 of the two's-complement negation.

Three 2:1 selectors assemble the result. The low function bit chooses the adder's second operand. The same bit chooses between the AND and OR results on the logic side. The high function bit chooses between the logic side and the adder. Every 2:1 selector passes its first input on select 0 and its second input on select 1. The carry out of the top bit is dropped, so every result is taken modulo 2^W.

There is no clock and no state. The result follows any change on an operand or on the function code.

Top module: `shared_adder_alu`

## Requirements
- R1: With function code 2'b00 the result equals the bitwise AND of the operands (0xFF AND 0x56 gives 0x56).
- R2: With function code 2'b01 the result equals the bitwise OR of the operands (0x2A OR 0x55 gives 0x7F).
- R3: With function code 2'b10 the result equals the operands' sum modulo 2^W, and the carry out is discarded (0x95 + 0xC1 gives 0x56).
- R4: With function code 2'b11 the result equals A plus the complement of B plus one, modulo 2^W (0xFF - 0x80 gives 0x7F).
- R5: Subtraction wraps when B exceeds A (0x00 - 0x01 gives 0xFF, and 0x00 - 0x80 gives 0x80).
- R6: A carry can ripple through every bit position. 0xFF + 0x01 gives 0x00, and A - 0x00 gives A, where complementing zero and adding the carry-in carries through all bits.
- R7: The block is combinational: after any change of A, B or the function code, the result settles to the new value without a clock edge.
- R8: Subtracting an operand from itself gives zero for every value of that operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | W (8) | First operand |
| opb | input | W (8) | Second operand; its complement is used when subtracting |
| fsel | input | 2 | Function code: 00 AND, 01 OR, 10 add, 11 subtract |
| res | output | W (8) | Result, modulo 2^W |

## Verification
The hardest case to reach is a carry that travels the full length of the chain. When subtracting zero, the complemented operand is all ones and the carry-in must ripple from bit 0 to the dropped top carry. A 0xFF + 0x01 addition has the same property. Neither case appears in ordinary operand pairs. Directed tasks therefore drive these pairs, along with the 0x00, 0x80 and 0xFF boundaries. An exhaustive sweep over every operand pair and every function code then compares each result with a modulo-256 reference model.

// File: rtl/alu_pkg.sv
`timescale 1ns/1ps
package alu_pkg;
  localparam int unsigned ALU_W_DEF = 8;

  typedef enum logic [1:0] {
    FN_AND = 2'b00,
    FN_OR  = 2'b01,
    FN_ADD = 2'b10,
    FN_SUB = 2'b11
  } alu_fn_e;

  // bit positions inside the function code
  localparam int unsigned FN_LOW_BIT  = 0; // operand invert, carry-in, AND/OR pick
  localparam int unsigned FN_HIGH_BIT = 1; // logic side vs adder
endpackage

// File: rtl/alu_mux2.sv
`timescale 1ns/1ps
module alu_mux2 #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] in0,
  input  logic [W-1:0] in1,
  input  logic         sel,
  output logic [W-1:0] out
);
  always_comb begin
    if (sel) out = in1;
    else     out = in0;
  end
endmodule

// File: rtl/alu_fa_cell.sv
`timescale 1ns/1ps
module alu_fa_cell (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);
  logic p;
  always_comb begin
    p  = x ^ y;
    s  = p ^ ci;
    co = (x & y) | (p & ci);
  end
endmodule

// File: rtl/alu_ripple_adder.sv
`timescale 1ns/1ps
module alu_ripple_adder #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum
);
  localparam int unsigned TOP = W - 1;

  // carry into each bit; the carry out of the top bit is never formed
  logic [TOP:0] cy;
  assign cy[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i < TOP) begin : g_cell
      alu_fa_cell u_fa (
        .x  (x[i]),
        .y  (y[i]),
        .ci (cy[i]),
        .s  (sum[i]),
        .co (cy[i+1])
      );
    end else begin : g_top
      assign sum[i] = x[i] ^ y[i] ^ cy[i];
    end
  end
endmodule

// File: rtl/shared_adder_alu.sv
`timescale 1ns/1ps
module shared_adder_alu #(
  parameter int unsigned W = alu_pkg::ALU_W_DEF
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [1:0]   fsel,
  output logic [W-1:0] res
);
  import alu_pkg::*;

  logic          sub_en;
  logic          arith_pick;
  logic [W-1:0]  opb_n;
  logic [W-1:0]  adder_y;
  logic [W-1:0]  adder_s;
  logic [W-1:0]  and_r;
  logic [W-1:0]  or_r;
  logic [W-1:0]  logic_r;

  assign sub_en     = fsel[FN_LOW_BIT];
  assign arith_pick = fsel[FN_HIGH_BIT];
  assign opb_n      = ~opb;
  assign and_r      = opa & opb;
  assign or_r       = opa | opb;

  // second adder operand: B or its complement
  alu_mux2 #(.W(W)) u_mux_opb (
    .in0 (opb),
    .in1 (opb_n),
    .sel (sub_en),
    .out (adder_y)
  );

  // shared adder, carry-in supplies the +1 of negation
  alu_ripple_adder #(.W(W)) u_adder (
    .x   (opa),
    .y   (adder_y),
    .cin (sub_en),
    .sum (adder_s)
  );

  // logic side: AND or OR
  alu_mux2 #(.W(W)) u_mux_logic (
    .in0 (and_r),
    .in1 (or_r),
    .sel (sub_en),
    .out (logic_r)
  );

  // final pick
  alu_mux2 #(.W(W)) u_mux_out (
    .in0 (logic_r),
    .in1 (adder_s),
    .sel (arith_pick),
    .out (res)
  );
endmodule

// File: rtl/shared_adder_alu_chk.sv
`timescale 1ns/1ps
module shared_adder_alu_chk #(
  parameter int unsigned W = 8
) (
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic [1:0]   fsel,
  input logic [W-1:0] res
);
  logic [W-1:0] ref_sum;
  logic [W-1:0] ref_diff;

  always_comb begin
    ref_sum  = opa + opb;
    ref_diff = opa - opb;
    if (!$isunknown({opa, opb, fsel, res})) begin
      // R1
      and_path_chk: assert (fsel != 2'b00 || res == (opa & opb))
        else $error("and_path_chk");
      // R2
      or_path_chk: assert (fsel != 2'b01 || res == (opa | opb))
        else $error("or_path_chk");
      // R3
      add_wrap_chk: assert (fsel != 2'b10 || res == ref_sum)
        else $error("add_wrap_chk");
      // R4
      sub_wrap_chk: assert (fsel != 2'b11 || res == ref_diff)
        else $error("sub_wrap_chk");
      // R8
      self_sub_zero_chk: assert (fsel != 2'b11 || opa != opb || res == '0)
        else $error("self_sub_zero_chk");
    end
  end
endmodule

bind shared_adder_alu shared_adder_alu_chk #(.W(W)) u_chk (
  .opa  (opa),
  .opb  (opb),
  .fsel (fsel),
  .res  (res)
);

// File: tb/shared_adder_alu_tb.sv
`timescale 1ns/1ps
module shared_adder_alu_tb;
  localparam int unsigned W = 8;

  logic         clk;
  logic [W-1:0] opa;
  logic [W-1:0] opb;
  logic [1:0]   fsel;
  logic [W-1:0] res;
  int           n_run;
  int           n_fail;
  bit           done;

  shared_adder_alu #(.W(W)) u_dut (
    .opa  (opa),
    .opb  (opb),
    .fsel (fsel),
    .res  (res)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [W-1:0] model(input logic [W-1:0] a,
                                         input logic [W-1:0] b,
                                         input logic [1:0] f);
    logic [W:0] wide;
    case (f)
      2'b00:   return a & b;
      2'b01:   return a | b;
      2'b10:   begin wide = {1'b0, a} + {1'b0, b}; return wide[W-1:0]; end
      default: begin wide = {1'b0, a} + {1'b0, ~b} + 1; return wide[W-1:0]; end
    endcase
  endfunction

  task automatic check(input string tag, input logic [W-1:0] got,
                       input logic [W-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: a=%h b=%h f=%b got=%h exp=%h", tag, opa, opb, fsel, got, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [1:0] f);
    opa = a; opb = b; fsel = f;
    #1;
  endtask

  task automatic t_start;
    apply('0, '0, 2'b00);
    check("R1 zero inputs", res, 8'h00);
  endtask

  task automatic t_logic;
    apply(8'hFF, 8'h56, 2'b00); check("R1", res, 8'h56);
    apply(8'hA5, 8'h3C, 2'b00); check("R1", res, 8'h24);
    apply(8'h2A, 8'h55, 2'b01); check("R2", res, 8'h7F);
    apply(8'h00, 8'h80, 2'b01); check("R2", res, 8'h80);
  endtask

  task automatic t_arith;
    apply(8'h95, 8'hC1, 2'b10); check("R3 carry dropped", res, 8'h56);
    apply(8'h12, 8'h34, 2'b10); check("R3", res, 8'h46);
    apply(8'hFF, 8'h80, 2'b11); check("R4", res, 8'h7F);
    apply(8'h50, 8'h20, 2'b11); check("R4", res, 8'h30);
  endtask

  task automatic t_wrap;
    apply(8'h00, 8'h01, 2'b11); check("R5", res, 8'hFF);
    apply(8'h00, 8'h80, 2'b11); check("R5", res, 8'h80);
    apply(8'hFF, 8'h01, 2'b10); check("R6 full ripple add", res, 8'h00);
    apply(8'h80, 8'h80, 2'b10); check("R6", res, 8'h00);
    apply(8'hC3, 8'h00, 2'b11); check("R6 minus zero", res, 8'hC3);
    apply(8'hFF, 8'h00, 2'b11); check("R6 minus zero", res, 8'hFF);
  endtask

  task automatic t_comb;
    // same operands, only the code moves: result follows with no clock
    apply(8'h6B, 8'h2D, 2'b00); check("R7", res, 8'h29);
    apply(8'h6B, 8'h2D, 2'b01); check("R7", res, 8'h6F);
    apply(8'h6B, 8'h2D, 2'b10); check("R7", res, 8'h98);
    apply(8'h6B, 8'h2D, 2'b11); check("R7", res, 8'h3E);
    apply(8'h6B, 8'h00, 2'b11); check("R7", res, 8'h6B);
  endtask

  task automatic t_self_sub;
    for (int v = 0; v < 256; v++) begin
      apply(v[W-1:0], v[W-1:0], 2'b11);
      check("R8", res, 8'h00);
    end
  endtask

  task automatic t_sweep;
    for (int f = 0; f < 4; f++) begin
      for (int a = 0; a < 256; a++) begin
        for (int b = 0; b < 256; b++) begin
          apply(a[W-1:0], b[W-1:0], f[1:0]);
          check(f == 0 ? "R1 sweep" : f == 1 ? "R2 sweep" :
                f == 2 ? "R3 sweep" : "R4 sweep",
                res, model(a[W-1:0], b[W-1:0], f[1:0]));
        end
      end
    end
  endtask

  initial begin
    n_run = 0; n_fail = 0; done = 1'b0;
    @(negedge clk);
    t_start();
    t_logic();
    t_arith();
    t_wrap();
    t_comb();
    t_self_sub();
    t_sweep();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule